// File: doc/BRIEF.md
# Descriptor-chained stream-to-memory DMA engine

This engine takes a byte stream, one byte per valid/ready beat with an end-of-packet marker, and stores it into memory buffers described by a linked chain of data descriptors. A descriptor occupies four consecutive 32-bit words: the address of the following descriptor, the buffer start pointer, a flags word, and the buffer limit pointer. Bytes are stored from the start pointer upward. A descriptor is closed either when its buffer is full or when a packet ends. A packet can therefore finish early, part way through a buffer.

When a descriptor closes, the engine rewrites its limit word with the real fill position and marks packet ends in its flags word. It also pulses set strobes toward an external raw-interrupt register. It then either loads the next descriptor in the chain or, at end of list, marks the channel context disabled and stops. While stopped, the stream is refused until software issues a new kick. Memory is reached through a simple word-wide port with per-byte enables and a read latency of one cycle.

Top module: `dma_s2m`

## Requirements
- R1: While reset is held and after it is released, `inReady`, `eolOut`, `memReq` and `rawSet` are all 0 until a kick.
- R2: A kick with the engine idle or stopped reads the four words at descriptor byte addresses +0, +4, +8 and +12. The word fields are next, start pointer, flags and limit. `inReady` stays 0 during any fetch or write-back.
- R3: Byte n of the stream lands at byte address P, in lane P mod 4 of the word at P with the low two bits cleared. Only lanes that received bytes have their byte enables set, so neighbouring bytes in memory are unchanged.
- R4: A descriptor accepts no more than limit minus start bytes. The next byte after that goes to the following descriptor.
- R5: A byte carrying end-of-packet closes the descriptor at once. The limit word is rewritten with the address after the last byte stored, and flags bit 11 is set.
- R6: On close, `rawSet` pulses for exactly one cycle. Bits 1 and 0 are set when flags bit 4 is 1, and bit 3 is set when the close was caused by end-of-packet. In every other cycle `rawSet` is 0.
- R7: When flags bit 0 is 1, the close writes the value 0x80 into byte lane 1 only of the word at context address +4, which sets disable bit 15. `eolOut` then rises and `inReady` stays 0 until the next kick.
- R8: A descriptor whose start equals its limit closes without taking a byte. Its limit stays the same and flags bit 11 stays clear.
- R9: A kick while stopped clears the end-of-list state and processes a fresh chain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| kick | input | 1 | Start pulse, honoured when idle or stopped |
| kickDesc | input | ADDR_W | Byte address of first descriptor |
| kickCtx | input | ADDR_W | Byte address of the channel context |
| inValid | input | 1 | Stream byte valid |
| inData | input | 8 | Stream byte |
| inEop | input | 1 | Byte is the last of its packet |
| inReady | output | 1 | Engine accepts the byte this cycle |
| memReq | output | 1 | Memory access this cycle |
| memWe | output | 1 | 1 write, 0 read |
| memAddr | output | ADDR_W | Word-aligned byte address |
| memWdata | output | 32 | Write data |
| memBe | output | 4 | Per-lane write enables |
| memRdata | input | 32 | Read data, valid the cycle after a read |
| rawSet | output | 4 | One-cycle set strobes for raw interrupt bits |
| eolOut | output | 1 | End of list reached, engine stopped |

## Verification
The bench builds the engine with ADDR_W of 16 and attaches a 1 KiB word memory, so descriptors, buffers and the context word all fit a small model image that is compared in full after each chain. Buffers are given start offsets of 0 to 3 and lengths of 0 to 12. This brings every lane alignment, partial first and last words, zero-length descriptors, and both close-on-full and close-on-packet-end within reach in a few hundred cycles per chain. Restarting from the stopped state after each chain exercises repeated kicks.

// File: rtl/s2m_pkg.sv
package s2m_pkg;
  localparam int WORD_W = 32;
  localparam int BYTES = WORD_W / 8;
  localparam int FLAG_EOL = 0;
  localparam int FLAG_INTR = 4;
  localparam int FLAG_INEOP = 11;
  localparam int CTX_DIS = 15;
  localparam int FETCH_WORDS = 4;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_RECV, S_WBF, S_WBA, S_CTX, S_STOP
  } s2mState_t;

  typedef struct packed {
    logic       loadKick;
    logic       loadNext;
    logic       rdIssue;
    logic [1:0] rdIdx;
    logic       capEn;
    logic [1:0] capIdx;
    logic       accept;
    logic       flush;
    logic       wbFlags;
    logic       wbAfter;
    logic       wbCtx;
  } s2mStrobe_t;
endpackage

// File: rtl/s2m_ctrl.sv
module s2m_ctrl
  import s2m_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       kick,
  input  logic       inValid,
  input  logic       inEop,
  input  logic       spaceZero,
  input  logic       lastByte,
  input  logic       laneLast,
  input  logic       descEol,
  output s2mStrobe_t str,
  output logic       inReady,
  output logic       eolOut
);
  localparam int CNT_W = $clog2(FETCH_WORDS + 1);

  s2mState_t st, nxt;
  logic [CNT_W-1:0] cnt;

  always_comb begin
    str = '0;
    nxt = st;
    inReady = 1'b0;
    case (st)
      S_IDLE, S_STOP: begin
        if (kick) begin
          str.loadKick = 1'b1;
          nxt = S_FETCH;
        end
      end
      S_FETCH: begin
        if (cnt < CNT_W'(FETCH_WORDS)) begin
          str.rdIssue = 1'b1;
          str.rdIdx = cnt[1:0];
        end
        if (cnt != '0) begin
          str.capEn = 1'b1;
          str.capIdx = 2'(cnt - CNT_W'(1));
        end
        if (cnt == CNT_W'(FETCH_WORDS)) nxt = S_RECV;
      end
      S_RECV: begin
        if (spaceZero) begin
          nxt = S_WBF;
        end else begin
          inReady = 1'b1;
          if (inValid) begin
            str.accept = 1'b1;
            str.flush = laneLast | lastByte | inEop;
            if (lastByte | inEop) nxt = S_WBF;
          end
        end
      end
      S_WBF: begin
        str.wbFlags = 1'b1;
        nxt = S_WBA;
      end
      S_WBA: begin
        str.wbAfter = 1'b1;
        if (descEol) begin
          nxt = S_CTX;
        end else begin
          str.loadNext = 1'b1;
          nxt = S_FETCH;
        end
      end
      S_CTX: begin
        str.wbCtx = 1'b1;
        nxt = S_STOP;
      end
      default: nxt = S_IDLE;
    endcase
  end

  assign eolOut = (st == S_STOP);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st <= S_IDLE;
      cnt <= '0;
    end else begin
      st <= nxt;
      cnt <= (st == S_FETCH) ? cnt + CNT_W'(1) : '0;
    end
  end
endmodule

// File: rtl/s2m_dp.sv
module s2m_dp
  import s2m_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  s2mStrobe_t        str,
  input  logic [ADDR_W-1:0] kickDesc,
  input  logic [ADDR_W-1:0] kickCtx,
  input  logic [7:0]        inData,
  input  logic              inEop,
  input  logic [WORD_W-1:0] memRdata,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWdata,
  output logic [BYTES-1:0]  memBe,
  output logic [3:0]        rawSet,
  output logic              spaceZero,
  output logic              lastByte,
  output logic              laneLast,
  output logic              descEol
);
  localparam int LANE_SEL = $clog2(BYTES);

  logic [ADDR_W-1:0] descAddr, ctxAddr, nextPtr, afterPtr, bufPtr;
  logic [WORD_W-1:0] flags, wordBuf, mergedWord;
  logic [BYTES-1:0]  wordBe, mergedBe;
  logic              eopHit;

  for (genvar l = 0; l < BYTES; l++) begin : gLane
    logic laneHit;
    assign laneHit = (bufPtr[LANE_SEL-1:0] == LANE_SEL'(l));
    assign mergedWord[8*l +: 8] = laneHit ? inData : wordBuf[8*l +: 8];
    assign mergedBe[l] = laneHit | wordBe[l];
  end

  assign spaceZero = (bufPtr == afterPtr);
  assign lastByte = ((bufPtr + ADDR_W'(1)) == afterPtr);
  assign laneLast = &bufPtr[LANE_SEL-1:0];
  assign descEol = flags[FLAG_EOL];

  always_comb begin
    memReq = 1'b0;
    memWe = 1'b0;
    memAddr = '0;
    memWdata = '0;
    memBe = '0;
    rawSet = '0;
    if (str.rdIssue) begin
      memReq = 1'b1;
      memAddr = descAddr + (ADDR_W'(str.rdIdx) << LANE_SEL);
    end else if (str.accept && str.flush) begin
      memReq = 1'b1;
      memWe = 1'b1;
      memAddr = {bufPtr[ADDR_W-1:LANE_SEL], LANE_SEL'(0)};
      memWdata = mergedWord;
      memBe = mergedBe;
    end else if (str.wbFlags) begin
      memReq = 1'b1;
      memWe = 1'b1;
      memAddr = descAddr + ADDR_W'(2 * BYTES);
      memWdata = flags;
      memWdata[FLAG_INEOP] = flags[FLAG_INEOP] | eopHit;
      memBe = '1;
      rawSet = {eopHit, 1'b0, flags[FLAG_INTR], flags[FLAG_INTR]};
    end else if (str.wbAfter) begin
      memReq = 1'b1;
      memWe = 1'b1;
      memAddr = descAddr + ADDR_W'(3 * BYTES);
      memWdata[ADDR_W-1:0] = bufPtr;
      memBe = '1;
    end else if (str.wbCtx) begin
      memReq = 1'b1;
      memWe = 1'b1;
      memAddr = ctxAddr + ADDR_W'(BYTES);
      memWdata[CTX_DIS] = 1'b1;
      memBe[CTX_DIS/8] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      descAddr <= '0;
      ctxAddr <= '0;
      nextPtr <= '0;
      afterPtr <= '0;
      bufPtr <= '0;
      flags <= '0;
      wordBuf <= '0;
      wordBe <= '0;
      eopHit <= 1'b0;
    end else begin
      if (str.loadKick) begin
        descAddr <= kickDesc;
        ctxAddr <= kickCtx;
        eopHit <= 1'b0;
      end
      if (str.loadNext) begin
        descAddr <= nextPtr;
        eopHit <= 1'b0;
      end
      if (str.capEn) begin
        case (str.capIdx)
          2'd0: nextPtr <= memRdata[ADDR_W-1:0];
          2'd1: bufPtr <= memRdata[ADDR_W-1:0];
          2'd2: flags <= memRdata;
          default: afterPtr <= memRdata[ADDR_W-1:0];
        endcase
      end
      if (str.accept) begin
        bufPtr <= bufPtr + ADDR_W'(1);
        eopHit <= inEop;
        if (str.flush) begin
          wordBuf <= '0;
          wordBe <= '0;
        end else begin
          wordBuf <= mergedWord;
          wordBe <= mergedBe;
        end
      end
    end
  end
endmodule

// File: rtl/dma_s2m.sv
module dma_s2m
  import s2m_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              kick,
  input  logic [ADDR_W-1:0] kickDesc,
  input  logic [ADDR_W-1:0] kickCtx,
  input  logic              inValid,
  input  logic [7:0]        inData,
  input  logic              inEop,
  output logic              inReady,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWdata,
  output logic [BYTES-1:0]  memBe,
  input  logic [WORD_W-1:0] memRdata,
  output logic [3:0]        rawSet,
  output logic              eolOut
);
  s2mStrobe_t str;
  logic spaceZero, lastByte, laneLast, descEol;

  s2m_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .kick(kick), .inValid(inValid), .inEop(inEop),
    .spaceZero(spaceZero), .lastByte(lastByte), .laneLast(laneLast),
    .descEol(descEol), .str(str), .inReady(inReady), .eolOut(eolOut)
  );

  s2m_dp #(.ADDR_W(ADDR_W)) uDp (
    .clk(clk), .rstN(rstN), .str(str), .kickDesc(kickDesc), .kickCtx(kickCtx),
    .inData(inData), .inEop(inEop), .memRdata(memRdata), .memReq(memReq),
    .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata), .memBe(memBe),
    .rawSet(rawSet), .spaceZero(spaceZero), .lastByte(lastByte),
    .laneLast(laneLast), .descEol(descEol)
  );
endmodule

// File: rtl/s2m_chk.sv
module s2m_chk (
  input logic       clk,
  input logic       rstN,
  input logic       inValid,
  input logic       inEop,
  input logic       inReady,
  input logic       memReq,
  input logic       memWe,
  input logic [3:0] memBe,
  input logic [3:0] rawSet,
  input logic       eolOut
);
  // R7: stopped engine refuses the stream
  a_r7_eol_blocks: assert property (@(posedge clk) disable iff (!rstN)
    eolOut |-> !inReady);

  // R2: no stream acceptance while a descriptor word is being read
  a_r2_fetch_no_ready: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memWe) |-> !inReady);

  // R3: every write carries at least one lane enable
  a_r3_be_present: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe) |-> (memBe != 4'b0));

  // R6: interrupt set bits 1 and 0 always move together
  a_r6_intr_pair: assert property (@(posedge clk) disable iff (!rstN)
    rawSet[1] == rawSet[0]);

  // R6: strobes last a single cycle
  a_r6_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    (rawSet != 4'b0) |=> (rawSet == 4'b0));

  // R5: an accepted packet end is followed by the flags write-back with bit 3 strobe
  a_r5_eop_close: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && inEop) |=> (memReq && memWe && rawSet[3]));
endmodule

bind dma_s2m s2m_chk uChk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inEop(inEop), .inReady(inReady),
  .memReq(memReq), .memWe(memWe), .memBe(memBe), .rawSet(rawSet), .eolOut(eolOut)
);

// File: tb/tb_dma_s2m.sv
`timescale 1ns/1ps
module tb_dma_s2m;
  localparam int AW = 16;
  localparam int CTXW = 253;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN, kick, inValid, inEop, inReady, memReq, memWe, eolOut;
  logic [AW-1:0] kickDesc, kickCtx, memAddr;
  logic [7:0] inData;
  logic [31:0] memWdata, memRdata;
  logic [3:0] memBe, rawSet;

  dma_s2m #(.ADDR_W(AW)) dut (
    .clk(clk), .rstN(rstN), .kick(kick), .kickDesc(kickDesc), .kickCtx(kickCtx),
    .inValid(inValid), .inData(inData), .inEop(inEop), .inReady(inReady),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memBe(memBe), .memRdata(memRdata), .rawSet(rawSet), .eolOut(eolOut)
  );

  // memory model with a backdoor write port
  logic [31:0] mem [0:255];
  logic bdWe = 1'b0;
  logic [7:0] bdIdx = '0;
  logic [31:0] bdData = '0;
  always @(posedge clk) begin
    if (bdWe) mem[bdIdx] <= bdData;
    if (memReq) begin
      if (memWe) begin
        for (int l = 0; l < 4; l++)
          if (memBe[l]) mem[memAddr[9:2]][8*l +: 8] <= memWdata[8*l +: 8];
      end else begin
        memRdata <= mem[memAddr[9:2]];
      end
    end
  end

  // monitors
  logic [3:0] obsP [0:63];
  int nObs = 0;
  logic [AW-1:0] rdLog [0:63];
  int nRd = 0;
  always @(negedge clk) begin
    if (rstN && rawSet != 4'b0) begin obsP[nObs & 63] = rawSet; nObs++; end
    if (rstN && memReq && !memWe) begin rdLog[nRd & 63] = memAddr; nRd++; end
  end

  int errors = 0, checks = 0;
  logic [31:0] expMem [0:255];
  logic [3:0] expP [0:63];
  int nExp;
  int mBuf[8], mAfter[8], mNext[8];
  logic [31:0] mFlags[8];
  int mCur, mPtr;
  bit mDone;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] pf(input int k);
    return {8'hC3, 8'(k), 8'(~k), 8'h3C};
  endfunction

  task automatic bdWrite(input int idx, input logic [31:0] d);
    bdWe = 1'b1; bdIdx = 8'(idx); bdData = d;
    @(negedge clk);
    bdWe = 1'b0;
    expMem[idx] = d;
  endtask

  task automatic writeDesc(input int i, input int nxt, input int b, input int a,
                           input bit intr, input bit eol, input logic [15:0] md);
    logic [31:0] fw;
    fw = {md, 16'h0} | (intr ? 32'h10 : 32'h0) | (eol ? 32'h1 : 32'h0);
    bdWrite(4*i, 32'(nxt)); bdWrite(4*i+1, 32'(b));
    bdWrite(4*i+2, fw); bdWrite(4*i+3, 32'(a));
    mBuf[i] = b; mAfter[i] = a; mNext[i] = nxt / 16; mFlags[i] = fw;
  endtask

  task automatic modelClose(input bit eop);
    int i;
    i = mCur;
    expMem[4*i+2] = mFlags[i] | (eop ? 32'h800 : 32'h0);
    expMem[4*i+3] = 32'(mPtr);
    if (mFlags[i][4] || eop) begin
      expP[nExp] = {eop, 1'b0, mFlags[i][4], mFlags[i][4]};
      nExp++;
    end
    if (mFlags[i][0]) begin
      mDone = 1'b1;
      expMem[CTXW][15:8] = 8'h80;
    end else begin
      mCur = mNext[i];
      mPtr = mBuf[mCur];
    end
  endtask

  task automatic modelEnter();
    while (!mDone && mPtr == mAfter[mCur]) modelClose(1'b0);
  endtask

  task automatic modelAccept(input logic [7:0] d, input bit e);
    chk(!mDone && mPtr < mAfter[mCur], "R4", "byte accepted beyond buffer space",
        mPtr, mAfter[mCur]);
    if (!mDone) begin
      expMem[mPtr >> 2][8*(mPtr & 3) +: 8] = d;
      mPtr++;
      if (e || mPtr == mAfter[mCur]) begin
        modelClose(e);
        modelEnter();
      end
    end
  endtask

  task automatic doKick();
    @(negedge clk);
    kick = 1'b1; kickDesc = '0; kickCtx = AW'(16'h3F0);
    @(negedge clk);
    kick = 1'b0;
    mCur = 0; mPtr = mBuf[0]; mDone = 1'b0;
    modelEnter();
  endtask

  task automatic sendByte(input logic [7:0] d, input bit e, input bit v, output bit acc);
    @(negedge clk);
    inValid = v; inData = d; inEop = e;
    #1;
    acc = v && inReady;
    if (acc) modelAccept(d, e);
  endtask

  task automatic compareAll(input string req);
    int bad, first;
    bad = 0; first = -1;
    for (int k = 0; k < 256; k++)
      if (mem[k] !== expMem[k]) begin bad++; if (first < 0) first = k; end
    if (first < 0) chk(1'b1, req, "memory image", 0, 0);
    else chk(1'b0, req, $sformatf("memory image word %0d", first), mem[first], expMem[first]);
  endtask

  task automatic comparePulses(input int base);
    chk(nObs - base == nExp, "R6", "interrupt strobe count", nObs - base, nExp);
    for (int k = 0; k < nExp && k < nObs - base; k++)
      chk(obsP[(base + k) & 63] == expP[k], "R6", "interrupt strobe value",
          obsP[(base + k) & 63], expP[k]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    bit acc;
    int base, rdBase;
    void'($urandom(32'd20240611));
    rstN = 1'b0; kick = 1'b0; kickDesc = '0; kickCtx = '0;
    inValid = 1'b0; inData = '0; inEop = 1'b0;
    repeat (3) @(negedge clk);
    chk(!inReady && !eolOut && !memReq && rawSet == 0, "R1", "outputs in reset",
        {inReady, eolOut, memReq, rawSet}, 0);
    rstN = 1'b1;
    for (int k = 0; k < 256; k++) bdWrite(k, pf(k));
    chk(!inReady && !eolOut && !memReq && rawSet == 0, "R1", "outputs idle after reset",
        {inReady, eolOut, memReq, rawSet}, 0);

    // directed chain
    writeDesc(0, 16, 'h201, 'h207, 1'b1, 1'b0, 16'hA1A1);
    writeDesc(1, 32, 'h220, 'h230, 1'b0, 1'b0, 16'hB2B2);
    writeDesc(2, 48, 'h240, 'h240, 1'b1, 1'b0, 16'hC3C3);
    writeDesc(3, 0, 'h262, 'h264, 1'b0, 1'b1, 16'hD4D4);
    base = nObs; nExp = 0; rdBase = nRd;
    doKick();
    chk(!inReady, "R2", "ready low during fetch", inReady, 0);
    for (int k = 0; k < 13; k++) begin
      acc = 1'b0;
      while (!acc) sendByte(8'(8'h10 + k), k == 10, 1'b1, acc);
    end
    @(negedge clk); inValid = 1'b0; inEop = 1'b0;
    for (int w = 0; w < 40 && !eolOut; w++) @(negedge clk);
    for (int k = 0; k < 4; k++)
      chk(rdLog[(rdBase + k) & 63] == AW'(4 * k), "R2", "descriptor fetch address",
          rdLog[(rdBase + k) & 63], 4 * k);
    chk(mem[128] == {8'h12, 8'h11, 8'h10, pf(128)[7:0]}, "R3", "lane placement, lane 0 kept",
        mem[128], {8'h12, 8'h11, 8'h10, pf(128)[7:0]});
    chk(mem[129] == {pf(129)[31:24], 8'h15, 8'h14, 8'h13}, "R4", "byte past limit untouched",
        mem[129], {pf(129)[31:24], 8'h15, 8'h14, 8'h13});
    chk(mem[7] == 32'h225, "R5", "limit rewritten on packet end", mem[7], 32'h225);
    chk(mem[6][11] == 1'b1, "R5", "in-packet-end flag", mem[6][11], 1);
    chk(mem[11] == 32'h240 && mem[10][11] == 1'b0, "R8", "zero-length descriptor",
        {mem[11], mem[10][11]}, {32'h240, 1'b0});
    chk(mem[CTXW] == {pf(CTXW)[31:16], 8'h80, pf(CTXW)[7:0]}, "R7", "context disable lane",
        mem[CTXW], {pf(CTXW)[31:16], 8'h80, pf(CTXW)[7:0]});
    chk(eolOut == 1'b1, "R7", "end of list reported", eolOut, 1);
    chk(nExp == 3 && expP[0] == 4'h3 && expP[1] == 4'h8 && expP[2] == 4'h3, "R6",
        "expected strobe list", nExp, 3);
    comparePulses(base);
    compareAll("R3");

    // refuse input while stopped
    begin
      int seen;
      seen = 0;
      for (int k = 0; k < 8; k++) begin
        sendByte(8'hEE, 1'b0, 1'b1, acc);
        if (inReady) seen++;
      end
      @(negedge clk); inValid = 1'b0;
      chk(seen == 0, "R7", "ready while stopped", seen, 0);
      compareAll("R7");
    end

    // random chains, each restarted by a kick
    for (int r = 0; r < 6; r++) begin
      int n;
      n = 1 + $urandom_range(0, 5);
      for (int i = 0; i < n; i++) begin
        int b;
        b = 'h200 + 'h20 * i + $urandom_range(0, 3);
        writeDesc(i, 16 * (i + 1), b, b + $urandom_range(0, 12),
                  1'($urandom_range(0, 1)), i == n - 1, 16'($urandom));
      end
      base = nObs; nExp = 0;
      doKick();
      for (int it = 0; it < 3000; it++) begin
        sendByte(8'($urandom), $urandom_range(0, 7) == 0, $urandom_range(0, 9) < 7, acc);
        if (eolOut) break;
      end
      @(negedge clk); inValid = 1'b0; inEop = 1'b0;
      chk(eolOut && mDone, "R9", "restarted chain reached end of list", {eolOut, mDone}, 3);
      compareAll("R9");
      comparePulses(base);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule